// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block is the digital side of a two-channel, double-buffered digital-to-analog converter. A host writes one frame at a time over a three-wire link made of an active-low select, a serial clock and a data line. Each frame carries a two-bit channel address and then the data word, most significant bit first. When the select line returns high, the block decodes the address and copies the data word into the input register of channel A, channel B, both channels, or neither.

A second register stage per channel holds the word that is presented to the converter. An active-low, level-sensitive load strobe makes this stage follow the input registers. Holding the strobe high lets both channels be written one after the other and then updated together. Tying it low gives single-buffered operation.

An active-low clear input forces every register to a preset value. A select pin chooses zero scale or midscale as that preset. The system reset loads zero into every register. All serial and control pins are sampled by a single system clock, so that clock must run at least four times faster than the serial clock.

Top module: `dual_dac_fe`

## Requirements
- R1: After the system reset (rst_ni low), both channel outputs and both input registers hold zero.
- R2: A frame is FRAME_W = DATA_W + 2 bits, shifted most significant bit first. Its first two bits are the address, with bit 1 of the address sent first, and the remaining DATA_W bits are the data word. With the default DATA_W of 16, a frame is 18 bits.
- R3: The data line is sampled only on a rising edge of the serial clock while the select line is low. Serial clock edges while the select line is high change no register.
- R4: When the select line rises, only the last FRAME_W bits shifted in are used, so a longer transfer works and its leading extra bits are discarded. A 24-bit transfer of three bytes is one example.
- R5: Address 2'b00 loads no input register.
- R6: Address 2'b01 loads channel A only. Address 2'b10 loads channel B only. Address 2'b11 loads the same word into both channels.
- R7: While the load strobe (ld_ni) is low, each output register follows its input register. While the strobe is high, both outputs hold their value.
- R8: With the load strobe held low, each channel output shows a newly committed word within a few system clocks of the select line rising.
- R9: While the clear input (clr_ni) is low, all four registers are forced to 0 if mid_sel_i is 0. If mid_sel_i is 1, they are forced to midscale, 1 << (DATA_W-1), which is 0x8000 for 16-bit data.
- R10: A rise of the select line after fewer than FRAME_W serial clock edges changes no register.
- R11: An active clear takes priority over a frame commit and over the load strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset; loads zero into all registers |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| csn_i | input | 1 | Active-low frame select; its rising edge commits the frame |
| sdi_i | input | 1 | Serial data, most significant bit first |
| ld_ni | input | 1 | Active-low, level-sensitive load strobe for the output registers |
| clr_ni | input | 1 | Active-low clear to the preset value |
| mid_sel_i | input | 1 | Preset select: 0 gives zero scale, 1 gives midscale |
| dac_a_o | output | DATA_W | Channel A output register |
| dac_b_o | output | DATA_W | Channel B output register |

## Verification
The input registers cannot be seen at the ports. The stimulus therefore holds the load strobe high across a burst of writes, checks that the outputs have not moved, and then pulses the strobe to bring both input registers out at once. The hardest case to reach is a clear that lands in the same cycle as a commit and an active strobe. The bench holds clear low while it finishes a frame with the strobe low. It then releases clear and checks that both channels still show the preset value and not the frame's data. Random frames with random addresses and random strobe modes are mixed with directed cases: a short frame, an oversize frame, and clock edges sent while the select line is high.

// File: rtl/dual_dac_fe_pkg.sv
package dual_dac_fe_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned N_CHAN = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_BOTH = 2'b11
  } chan_sel_e;
endpackage

// File: rtl/dual_dac_fe_sync.sv
module dual_dac_fe_sync #(
  parameter int unsigned WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dual_dac_fe_shifter.sv
module dual_dac_fe_shifter
  import dual_dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              csn_s_i,
  input  logic              sdi_s_i,
  output logic              commit_o,
  output chan_sel_e         addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned FRAME_W = DATA_W + ADDR_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d_q, csn_d_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, csn_rise;

  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign csn_rise  = csn_s_i & ~csn_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      csn_d_q  <= 1'b1;
      sr_q     <= '0;
      cnt_q    <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      csn_d_q  <= csn_s_i;
      if (csn_s_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sr_q <= {sr_q[FRAME_W-2:0], sdi_s_i};
        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Commit only a complete frame; the counter is cleared one cycle after the rise.
  assign commit_o = csn_rise && (cnt_q == CNT_FULL);
  assign addr_o   = chan_sel_e'(sr_q[FRAME_W-1 -: ADDR_W]);
  assign data_o   = sr_q[DATA_W-1:0];
endmodule

// File: rtl/dual_dac_fe_chan.sv
module dual_dac_fe_chan #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              mid_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              xfer_i,
  output logic [DATA_W-1:0] in_o,
  output logic [DATA_W-1:0] dac_o
);
  localparam logic [DATA_W-1:0] MID_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] preset;
  assign preset = mid_i ? MID_VAL : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_o  <= '0;
      dac_o <= '0;
    end else if (clr_i) begin
      in_o  <= preset;
      dac_o <= preset;
    end else begin
      if (wr_i)   in_o  <= din_i;
      if (xfer_i) dac_o <= in_o;
    end
  end
endmodule

// File: rtl/dual_dac_fe.sv
module dual_dac_fe
  import dual_dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              ld_ni,
  input  logic              clr_ni,
  input  logic              mid_sel_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o
);
  localparam int unsigned N_SYNC = 6;
  // bit order: mid_sel, clr_n, ld_n, sdi, csn, sclk
  localparam logic [N_SYNC-1:0] SYNC_RST = 6'b011010;

  logic [N_SYNC-1:0] raw_in, sync_out;
  logic sclk_s, csn_s, sdi_s, ld_act, clr_act, mid_s;

  assign raw_in = {mid_sel_i, clr_ni, ld_ni, sdi_i, csn_i, sclk_i};

  dual_dac_fe_sync #(.WIDTH(N_SYNC), .RST_VAL(SYNC_RST)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign sclk_s  = sync_out[0];
  assign csn_s   = sync_out[1];
  assign sdi_s   = sync_out[2];
  assign ld_act  = ~sync_out[3];
  assign clr_act = ~sync_out[4];
  assign mid_s   = sync_out[5];

  logic              commit;
  chan_sel_e         frame_addr;
  logic [DATA_W-1:0] frame_data;

  dual_dac_fe_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(sclk_s),
    .csn_s_i (csn_s),
    .sdi_s_i (sdi_s),
    .commit_o(commit),
    .addr_o  (frame_addr),
    .data_o  (frame_data)
  );

  logic [N_CHAN-1:0]             wr_sel;
  logic [N_CHAN-1:0][DATA_W-1:0] in_q;
  logic [N_CHAN-1:0][DATA_W-1:0] dac_q;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    // address bit c selects channel c (bit 0 = A, bit 1 = B)
    assign wr_sel[c] = commit & frame_addr[c];

    dual_dac_fe_chan #(.DATA_W(DATA_W)) chan_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_act),
      .mid_i (mid_s),
      .wr_i  (wr_sel[c]),
      .din_i (frame_data),
      .xfer_i(ld_act),
      .in_o  (in_q[c]),
      .dac_o (dac_q[c])
    );
  end

  assign dac_a_o = dac_q[0];
  assign dac_b_o = dac_q[1];
endmodule

// File: rtl/dual_dac_fe_chk.sv
module dual_dac_fe_chk
  import dual_dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             clr_act,
  input logic                             mid_s,
  input logic                             ld_act,
  input logic                             commit,
  input chan_sel_e                        frame_addr,
  input logic [DATA_W-1:0]                frame_data,
  input logic [N_CHAN-1:0][DATA_W-1:0]    in_q,
  input logic [N_CHAN-1:0][DATA_W-1:0]    dac_q
);
  localparam logic [DATA_W-1:0] MID_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  // R9 / R11
  a_r9_clear_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act |=> (dac_q[0] == ($past(mid_s) ? MID_VAL : '0)) &&
                (dac_q[1] == dac_q[0]) && (in_q[0] == dac_q[0]) && (in_q[1] == dac_q[0]));

  // R5
  a_r5_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_act && (!commit || frame_addr == SEL_NONE)) |=> $stable(in_q));

  // R6
  a_r6_load_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_act && commit && frame_addr[0]) |=> in_q[0] == $past(frame_data));

  a_r6_load_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_act && commit && frame_addr[1]) |=> in_q[1] == $past(frame_data));

  // R7
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_act && !ld_act) |=> $stable(dac_q));

  a_r7_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_act && ld_act) |=> dac_q == $past(in_q));
endmodule

bind dual_dac_fe dual_dac_fe_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_act   (clr_act),
  .mid_s     (mid_s),
  .ld_act    (ld_act),
  .commit    (commit),
  .frame_addr(frame_addr),
  .frame_data(frame_data),
  .in_q      (in_q),
  .dac_q     (dac_q)
);

// File: tb/dual_dac_fe_tb.sv
module dual_dac_fe_tb_top;
  localparam int DW = 16;
  localparam int FW = DW + 2;
  localparam logic [DW-1:0] MID = 16'h8000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0;
  logic ld_ni = 1'b1, clr_ni = 1'b1, mid_sel_i = 1'b0;
  logic [DW-1:0] dac_a_o, dac_b_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] e_in_a = '0, e_in_b = '0, e_dac_a = '0, e_dac_b = '0;

  always #2 clk_i = ~clk_i;

  dual_dac_fe #(.DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
    .ld_ni(ld_ni), .clr_ni(clr_ni), .mid_sel_i(mid_sel_i),
    .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
  );

  function automatic logic [FW-1:0] mk_frame(logic [1:0] a, logic [DW-1:0] d);
    return {a, d};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // apply expected model of a committed frame
  task automatic model_commit(logic [1:0] a, logic [DW-1:0] d);
    if (a[0]) e_in_a = d;
    if (a[1]) e_in_b = d;
  endtask

  task automatic model_ld();
    if (!ld_ni) begin e_dac_a = e_in_a; e_dac_b = e_in_b; end
  endtask

  task automatic shift_bits(int n, logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_i = v[i];
      wait_clk(4);
      sclk_i = 1'b1;
      wait_clk(4);
      sclk_i = 1'b0;
    end
  endtask

  task automatic send(int n, logic [31:0] v);
    wait_clk(2);
    csn_i = 1'b0;
    wait_clk(4);
    shift_bits(n, v);
    wait_clk(4);
    csn_i = 1'b1;
    wait_clk(10);
  endtask

  task automatic check(string req, logic [DW-1:0] ea, logic [DW-1:0] eb);
    n_run++;
    if (dac_a_o !== ea || dac_b_o !== eb) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h expected a=%h b=%h", req, dac_a_o, dac_b_o, ea, eb);
    end
  endtask

  task automatic pulse_ld();
    ld_ni = 1'b0;
    wait_clk(8);
    model_ld();
    ld_ni = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0]    a;
    logic [DW-1:0] d;
    void'($urandom(32'd20240611));
    wait_clk(3);
    check("R1", '0, '0);
    rst_ni = 1'b1;
    wait_clk(6);
    check("R1", '0, '0);

    // R2/R6: channel A, double-buffered, outputs hold (R7)
    send(FW, 32'(mk_frame(2'b01, 16'h1234)));
    model_commit(2'b01, 16'h1234);
    check("R7", e_dac_a, e_dac_b);
    pulse_ld();
    check("R2", 16'h1234, 16'h0000);

    // R6: channel B only, then both
    send(FW, 32'(mk_frame(2'b10, 16'hBEEF)));
    model_commit(2'b10, 16'hBEEF);
    pulse_ld();
    check("R6", 16'h1234, 16'hBEEF);
    send(FW, 32'(mk_frame(2'b11, 16'h5A5A)));
    model_commit(2'b11, 16'h5A5A);
    pulse_ld();
    check("R6", 16'h5A5A, 16'h5A5A);

    // R5: address none
    send(FW, 32'(mk_frame(2'b00, 16'h0F0F)));
    pulse_ld();
    check("R5", 16'h5A5A, 16'h5A5A);

    // R4: 24-bit transfer, six leading ones discarded
    send(24, {8'h00, 6'b111111, mk_frame(2'b01, 16'hC001)});
    model_commit(2'b01, 16'hC001);
    pulse_ld();
    check("R4", 16'hC001, 16'h5A5A);

    // R10: short frame ignored
    send(FW - 1, 32'(mk_frame(2'b11, 16'h7777)));
    pulse_ld();
    check("R10", 16'hC001, 16'h5A5A);

    // R3: serial clock edges while select is high
    sdi_i = 1'b1;
    shift_bits(FW, 32'h3FFFF);
    pulse_ld();
    check("R3", 16'hC001, 16'h5A5A);
    send(FW, 32'(mk_frame(2'b10, 16'h0042)));
    model_commit(2'b10, 16'h0042);
    pulse_ld();
    check("R3", 16'hC001, 16'h0042);

    // R8: strobe tied low
    ld_ni = 1'b0;
    send(FW, 32'(mk_frame(2'b01, 16'h9999)));
    model_commit(2'b01, 16'h9999);
    model_ld();
    check("R8", 16'h9999, 16'h0042);

    // R9: clear to midscale then zero
    mid_sel_i = 1'b1;
    clr_ni = 1'b0;
    wait_clk(8);
    check("R9", MID, MID);
    mid_sel_i = 1'b0;
    wait_clk(8);
    check("R9", 16'h0000, 16'h0000);
    clr_ni = 1'b1;
    wait_clk(6);
    check("R9", 16'h0000, 16'h0000);

    // R11: clear active across a commit with strobe low
    mid_sel_i = 1'b1;
    clr_ni = 1'b0;
    send(FW, 32'(mk_frame(2'b11, 16'h1111)));
    check("R11", MID, MID);
    clr_ni = 1'b1;
    wait_clk(8);
    check("R11", MID, MID);
    e_in_a = MID; e_in_b = MID; e_dac_a = MID; e_dac_b = MID;
    ld_ni = 1'b1;
    wait_clk(4);

    // random frames, random strobe mode
    for (int k = 0; k < 40; k++) begin
      a = 2'($urandom_range(0, 3));
      d = DW'($urandom);
      ld_ni = ($urandom_range(0, 1) == 0);
      wait_clk(4);
      model_ld();
      send(FW, 32'(mk_frame(a, d)));
      model_commit(a, d);
      model_ld();
      check(a == 2'b00 ? "R5" : "R6", e_dac_a, e_dac_b);
      if (ld_ni) begin
        pulse_ld();
        check("R7", e_dac_a, e_dac_b);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule